// File: doc/BRIEF.md
# Serial Frame Receiver: NRZI Decode, Bit Destuffing and CRC-16 Check

This block receives one frame of hard-decision line levels, one level per cycle when the level strobe is high. The pipeline has three stages. It first turns level transitions into bits. It then drops the zero that the transmitter inserts after every run of five ones. It then passes the remaining information bits through a serial CRC-16 register.

The frame begins with an external start pulse and has a fixed length of 184 information bits: 168 payload bits followed by the 16 transmitted CRC bits. The receiver does not compare the computed CRC with the received one. It runs the register over payload and CRC together and requires the remainder to be zero.

After the last information bit, a one-cycle done pulse is raised. A pass flag then stays valid until the next start. The destuffed bit stream, with its valid flag, is available for the logic that follows. The bit stream, the removed-bit count and the violation flag are also visible to that logic.

Top module: `nrzi_frame_rx`

## Requirements
- R1: A line level equal to the previous accepted level decodes to 1, and a different level decodes to 0. The first level accepted after `start_i` only sets the reference and yields no bit.
- R2: The decoded bit that follows five consecutive kept 1s is removed and the run count restarts. It is not output and does not enter the CRC. Every other decoded bit appears on `bit_o` with `bit_vld_o` high, two clock edges after its level is sampled.
- R3: When a removed bit is 1 instead of 0, `viol_o` is set and stays high until the next `start_i`. That bit is still removed.
- R4: `stuff_cnt_o` equals the number of bits removed in the current frame.
- R5: The CRC register is preset to 0xFFFF and uses polynomial 0x1021. It shifts MSB first: the feedback is the register MSB XOR the input bit. It is fed only kept bits, and a correct frame is its payload followed by the final register value, MSB first, which leaves a zero remainder.
- R6: `done_o` pulses for exactly one cycle, in the cycle after the 184th kept bit is on `bit_o`. At that point `pass_o` is set to 1 only if three conditions hold: the remainder is zero, `stuff_cnt_o` is at most 4, and `viol_o` is low. `pass_o` then holds its value until the next `start_i`.
- R7: After the 184th kept bit, further levels produce no output bits, no count change and no second done pulse until the next `start_i`.
- R8: `start_i` clears all frame state in the following cycle, including a frame that is only partly received. A level presented in the start cycle is ignored.
- R9: After reset, `bit_vld_o`, `done_o`, `pass_o`, `viol_o` and `stuff_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse, clears frame state |
| lvl_i | input | 1 | Hard-decision line level |
| lvl_vld_i | input | 1 | Line level valid strobe |
| bit_o | output | 1 | Destuffed information bit |
| bit_vld_o | output | 1 | `bit_o` is valid this cycle |
| stuff_cnt_o | output | SCW (6) | Bits removed in this frame |
| viol_o | output | 1 | A removed bit was 1 |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| pass_o | output | 1 | Frame accepted, valid from done until next start |

## Verification
The assertions cover properties that hold on every cycle:
- `done_o` is a single-cycle pulse.
- `pass_o` rises only with done, and never while a violation is flagged or the removed-bit count is above the limit.
- The violation flag is sticky.
- The removed-bit count never decreases within a frame.
- A start pulse clears the frame state.

The bench scenarios cover what needs a reference frame. These are the exact destuffed bit sequence, the count of removed bits, the CRC remainder and the pass decision for frames built in the bench. The frames use swept runs of ones, random payloads, line gaps, a flipped bit, an injected violation, trailing levels and a restart mid-frame.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;
  localparam int unsigned INFO_BITS = 184;
  localparam int unsigned RUN_LEN   = 5;
  localparam int unsigned MAX_STUFF = 4;
  localparam int unsigned CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
endpackage

// File: rtl/nrzi_dec.sv
module nrzi_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  input  logic vld_i,
  output logic bit_o,
  output logic vld_o
);
  logic ref_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b1;
      first_q <= 1'b1;
      bit_o   <= 1'b0;
      vld_o   <= 1'b0;
    end else if (clr_i) begin
      ref_q   <= 1'b1;
      first_q <= 1'b1;
      bit_o   <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= vld_i && !first_q;
      if (vld_i) begin
        bit_o   <= (lvl_i == ref_q);
        ref_q   <= lvl_i;
        first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bit_destuff.sv
module bit_destuff #(
  parameter int unsigned NINFO = 184,
  parameter int unsigned RUN   = 5,
  parameter int unsigned SCW   = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           bit_i,
  input  logic           vld_i,
  output logic           bit_o,
  output logic           vld_o,
  output logic           last_o,
  output logic [SCW-1:0] stuff_cnt_o,
  output logic           viol_o
);
  localparam int unsigned ICW = $clog2(NINFO + 1);
  localparam int unsigned RCW = $clog2(RUN + 1);

  logic [ICW-1:0] info_q;
  logic [RCW-1:0] run_q;
  logic           active, at_run;

  assign active = (info_q != ICW'(NINFO));
  assign at_run = (run_q == RCW'(RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q <= '0; run_q <= '0; stuff_cnt_o <= '0; viol_o <= 1'b0;
      bit_o <= 1'b0; vld_o <= 1'b0; last_o <= 1'b0;
    end else if (clr_i) begin
      info_q <= '0; run_q <= '0; stuff_cnt_o <= '0; viol_o <= 1'b0;
      bit_o <= 1'b0; vld_o <= 1'b0; last_o <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
      if (vld_i && active) begin
        if (at_run) begin
          // inserted bit: drop it, expect a zero
          run_q       <= '0;
          stuff_cnt_o <= stuff_cnt_o + 1'b1;
          if (bit_i) viol_o <= 1'b1;
        end else begin
          bit_o  <= bit_i;
          vld_o  <= 1'b1;
          run_q  <= bit_i ? run_q + 1'b1 : '0;
          info_q <= info_q + 1'b1;
          last_o <= (info_q == ICW'(NINFO - 1));
        end
      end
    end
  end
endmodule

// File: rtl/crc_ser.sv
module crc_ser #(
  parameter int unsigned   CW   = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] INIT = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          bit_i,
  input  logic          vld_i,
  output logic [CW-1:0] crc_nxt_o
);
  logic [CW-1:0] crc_q;
  logic          fb;

  assign fb        = crc_q[CW-1] ^ bit_i;
  assign crc_nxt_o = {crc_q[CW-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (vld_i)  crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/nrzi_frame_rx.sv
module nrzi_frame_rx
  import nrzi_rx_pkg::*;
#(
  parameter int unsigned   NINFO = INFO_BITS,
  parameter int unsigned   RUN   = RUN_LEN,
  parameter int unsigned   MAXS  = MAX_STUFF,
  parameter int unsigned   CW    = CRC_W,
  parameter logic [CW-1:0] POLY  = CRC_POLY,
  parameter logic [CW-1:0] INIT  = CRC_INIT,
  parameter int unsigned   SCW   = $clog2(NINFO / RUN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           lvl_i,
  input  logic           lvl_vld_i,
  output logic           bit_o,
  output logic           bit_vld_o,
  output logic [SCW-1:0] stuff_cnt_o,
  output logic           viol_o,
  output logic           done_o,
  output logic           pass_o
);
  logic          dec_bit, dec_vld, ds_last;
  logic [CW-1:0] crc_nxt;

  nrzi_dec u_dec (
    .clk_i, .rst_ni, .clr_i(start_i),
    .lvl_i, .vld_i(lvl_vld_i),
    .bit_o(dec_bit), .vld_o(dec_vld)
  );

  bit_destuff #(.NINFO(NINFO), .RUN(RUN), .SCW(SCW)) u_ds (
    .clk_i, .rst_ni, .clr_i(start_i),
    .bit_i(dec_bit), .vld_i(dec_vld),
    .bit_o, .vld_o(bit_vld_o), .last_o(ds_last),
    .stuff_cnt_o, .viol_o
  );

  crc_ser #(.CW(CW), .POLY(POLY), .INIT(INIT)) u_crc (
    .clk_i, .rst_ni, .clr_i(start_i),
    .bit_i(bit_o), .vld_i(bit_vld_o),
    .crc_nxt_o(crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (start_i) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= ds_last;
      if (ds_last)
        pass_o <= (crc_nxt == '0) && (stuff_cnt_o <= SCW'(MAXS)) && !viol_o;
    end
  end
endmodule

// File: rtl/nrzi_frame_rx_chk.sv
module nrzi_frame_rx_chk #(
  parameter int unsigned SCW  = 6,
  parameter int unsigned MAXS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           bit_vld_o,
  input logic [SCW-1:0] stuff_cnt_o,
  input logic           viol_o,
  input logic           done_o,
  input logic           pass_o
);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pass_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);

  p_pass_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (!viol_o && stuff_cnt_o <= SCW'(MAXS)));

  p_viol_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !start_i) |=> viol_o);

  p_stuff_mono_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> stuff_cnt_o >= $past(stuff_cnt_o));

  p_quiet_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bit_vld_o);

  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!bit_vld_o && !done_o && !pass_o && !viol_o && stuff_cnt_o == '0));
endmodule

bind nrzi_frame_rx nrzi_frame_rx_chk #(.SCW(SCW), .MAXS(MAXS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bit_vld_o(bit_vld_o),
  .stuff_cnt_o(stuff_cnt_o), .viol_o(viol_o), .done_o(done_o), .pass_o(pass_o)
);

// File: tb/sim_nrzi_frame_rx.sv
module sim_nrzi_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, lvl = 1'b1, lvl_vld = 1'b0;
  logic bit_q, bit_vld, viol, done, pass;
  logic [5:0] scnt;

  always #5 clk = ~clk;

  nrzi_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lvl_i(lvl), .lvl_vld_i(lvl_vld),
    .bit_o(bit_q), .bit_vld_o(bit_vld), .stuff_cnt_o(scnt),
    .viol_o(viol), .done_o(done), .pass_o(pass)
  );

  int n_cmp = 0, n_err = 0, cyc = 0;
  bit info [0:183];
  bit lv [0:299];
  bit got [0:183];
  int nlv, exp_stuff, got_n, done_n;
  bit exp_viol, exp_pass;
  logic [31:0] rs = 32'h1234_5678;

  function automatic bit rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs[0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (start) begin got_n = 0; done_n = 0; end
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (bit_vld) begin
      if (got_n < 184) got[got_n] = bit_q;
      got_n++;
    end
    if (done) done_n++;
  end

  // kind 0: par groups of five ones; kind 1: random seed par; kind 2: all ones
  task automatic build(input int kind, input int par, input bit flip, input bit inj);
    logic [15:0] c = 16'hFFFF;
    bit l, fb, first_stuff;
    int run;
    rs = 32'hACE1_0000 ^ par;
    for (int i = 0; i < 168; i++) begin
      case (kind)
        0: info[i] = (i / 8 < par) && (i % 8 < 5);
        1: info[i] = rnd();
        default: info[i] = 1'b1;
      endcase
    end
    // R5: preset FFFF, poly 1021, MSB-first; CRC sent MSB first
    for (int i = 0; i < 168; i++) begin
      fb = c[15] ^ info[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    for (int j = 0; j < 16; j++) info[168 + j] = c[15 - j];
    if (flip) info[37] = ~info[37];
    l = par[0];
    lv[0] = l; nlv = 1; run = 0; exp_stuff = 0; exp_viol = 0; first_stuff = 1;
    for (int i = 0; i < 184; i++) begin
      l = info[i] ? l : ~l;
      lv[nlv] = l; nlv++;
      run = info[i] ? run + 1 : 0;
      if (run == 5 && i < 183) begin
        if (inj && first_stuff) exp_viol = 1;
        else l = ~l;
        first_stuff = 0;
        lv[nlv] = l; nlv++;
        exp_stuff++; run = 0;
      end
    end
    exp_pass = !flip && !exp_viol && exp_stuff <= 4;
  endtask

  task automatic send(input bit gaps, input int extra, input int cut);
    int lim;
    @(negedge clk); start = 1'b1; lvl_vld = 1'b1; lvl = rnd();   // R8: ignored level
    @(negedge clk); start = 1'b0; lvl_vld = 1'b0;
    chk("R8 cleared after start", int'(scnt) + viol + pass + done + bit_vld, 0);
    lim = (cut > 0) ? cut : nlv;
    for (int k = 0; k < lim; k++) begin
      if (gaps) while (rnd() && rnd()) begin
        lvl_vld = 1'b0; lvl = rnd(); @(negedge clk);
      end
      lvl = lv[k]; lvl_vld = 1'b1; @(negedge clk);
    end
    for (int k = 0; k < extra; k++) begin
      lvl = rnd(); lvl_vld = 1'b1; @(negedge clk);
    end
    lvl_vld = 1'b0;
    if (cut == 0) repeat (6) @(negedge clk);
  endtask

  task automatic verify(input string tag);
    int mis = 0;
    for (int i = 0; i < 184; i++) if (got[i] != info[i]) mis++;
    chk({"R1 R2 bit count ", tag}, got_n, 184);
    chk({"R1 R2 bit mismatches ", tag}, mis, 0);
    chk({"R4 stuff count ", tag}, int'(scnt), exp_stuff);
    chk({"R3 violation ", tag}, viol, exp_viol);
    chk({"R6 done pulses ", tag}, done_n, 1);
    chk({"R5 R6 pass ", tag}, pass, exp_pass);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", int'(scnt) + viol + pass + done + bit_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", int'(scnt) + viol + pass + done + bit_vld, 0);

    for (int g = 0; g <= 8; g++) begin        // R4 R6 stuff-limit sweep
      build(0, g, 0, 0); send(0, 0, 0); verify($sformatf("groups=%0d", g));
    end
    for (int s = 1; s <= 6; s++) begin        // R5 random payloads, R1 line gaps
      build(1, s * 7919, 0, 0); send(s % 2, 0, 0); verify($sformatf("seed=%0d", s));
    end
    build(2, 0, 0, 0); send(0, 0, 0); verify("all ones");
    build(1, 99, 1, 0); send(0, 0, 0); verify("R5 flipped bit");
    build(0, 2, 0, 1); send(1, 0, 0); verify("R3 injected violation");
    build(1, 5, 0, 0); send(0, 40, 0); verify("R7 trailing levels");
    chk("R7 no stuff change after end", int'(scnt), exp_stuff);
    build(2, 3, 0, 1); send(0, 0, 120);       // partial frame then restart
    build(0, 3, 0, 0); send(1, 0, 0); verify("R8 restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule